// File: doc/BRIEF.md
# Memory-Backed Sample Histogram Engine

This block turns a stream of 24-bit samples into a histogram held in an external single-port synchronous memory. A start strobe first sweeps the whole memory and writes zero into every bin. The block then waits for samples. Each accepted sample picks a bin from its upper bits. The block reads that bin, adds one to the count and writes the count back.

Accumulation ends as soon as any bin reaches a target count that is set from an input. The block then drops busy and raises done, and holds done until the next start. The sample source, the channel and phase selection upstream, and the host readout of the finished histogram all sit outside this block. A sample that arrives while a bin update is still running is discarded and counted, so the user can tell how many samples the histogram missed.

Top module: `hist_accum`

## Requirements
- R1: After a start strobe the block spends exactly 2^ADDR_W cycles writing 0 to every address, 0 first and ascending, with busy high. Samples that arrive during this sweep are neither binned nor counted as dropped.
- R2: The bin index is the top ADDR_W bits of the sample, smp_data_i[SAMPLE_W-1 -: ADDR_W]. The lower bits have no effect.
- R3: Each accepted sample reads its bin, adds 1 to the CNT_W-bit count and writes the result back to the same address. Accepting the sample, reading, incrementing and writing take four cycles in total.
- R4: A sample that is valid while a read, increment or write is in progress is discarded. It adds 1 to drop_cnt_o, which saturates at its maximum and returns to 0 on start.
- R5: When the incremented count is greater than or equal to target_i (unsigned), done_o rises and busy_o falls in the cycle after that write. Otherwise accumulation continues with done_o low.
- R6: done_o stays high until the next start. While done or idle, samples change no memory contents and no drop count.
- R7: A start strobe while busy abandons the current activity and begins the clear sweep again from address 0, with done low.
- R8: After reset, busy_o, done_o and mem_we_o are 0 and drop_cnt_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start strobe: clear memory, then accumulate |
| target_i | input | CNT_W (16) | Count at which accumulation stops |
| smp_valid_i | input | 1 | Sample present this cycle |
| smp_data_i | input | SAMPLE_W (24) | Sample value |
| mem_addr_o | output | ADDR_W (15) | Memory address |
| mem_we_o | output | 1 | Memory write enable (a read when low) |
| mem_wdata_o | output | CNT_W (16) | Memory write data |
| mem_rdata_i | input | CNT_W (16) | Memory read data, valid one cycle after the address |
| busy_o | output | 1 | Clearing or accumulating |
| done_o | output | 1 | A bin reached the target |
| drop_cnt_o | output | DROP_W (16) | Samples discarded during updates |

## Verification
Two things can happen in the same cycle: a sample can arrive, and an earlier sample's read-increment-write can still be in flight. The bench provokes this by holding sample-valid high for five consecutive cycles into one bin. The first and fifth samples must land in that bin and the middle three must be counted as dropped, so the bin must read 2 and the drop count 3. A start strobe in the middle of the same run, with valid samples arriving during the new sweep, checks that restarting takes priority over both accumulation and drop counting.

// File: rtl/hist_acc_pkg.sv
// Package: shared controller state type for the histogram engine.
// Assumes nothing beyond SystemVerilog enum support.
package hist_acc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_WAIT,
        ST_READ,
        ST_INCR,
        ST_WRITE,
        ST_DONE
    } hist_state_e;
endpackage

// File: rtl/hist_clear_sweep.sv
// Module: address counter for the memory clear sweep.
// Counts up while run is high and returns to 0 on restart. last flags the
// final address. Assumes the sweep covers the full 2^ADDR_W space.
module hist_clear_sweep #(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              run,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);
    logic [ADDR_W-1:0] cnt_q;

    // Sweep address: reset or restart to zero, advance during the sweep.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) cnt_q <= '0;
        else if (run)          cnt_q <= cnt_q + 1'b1;
    end

    assign addr = cnt_q;
    assign last = (cnt_q == {ADDR_W{1'b1}});
endmodule

// File: rtl/hist_bin_update.sv
// Module: increment stage of the read-increment-write update.
// Captures the read data plus one, and compares the new count with the
// target (unsigned, greater or equal). Assumes read data is valid when
// load is high.
module hist_bin_update #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] rdata,
    input  logic [CNT_W-1:0] target,
    output logic [CNT_W-1:0] count_q,
    output logic             hit
);
    // Incremented count register.
    always_ff @(posedge clk) begin
        if (!rst_n)    count_q <= '0;
        else if (load) count_q <= rdata + 1'b1;
    end

    assign hit = (count_q >= target);
endmodule

// File: rtl/hist_drop_counter.sv
// Module: saturating counter of samples discarded during updates.
// Clears on start. Assumes inc and clear are never both needed at once
// (clear wins).
module hist_drop_counter #(
    parameter int DROP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              inc,
    output logic [DROP_W-1:0] cnt
);
    localparam logic [DROP_W-1:0] MAXV = {DROP_W{1'b1}};

    // Drop count: clear, or add one until saturated.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)           cnt <= '0;
        else if (inc && (cnt != MAXV)) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/hist_accum.sv
// Module: histogram engine top. Clears an external single-port memory,
// then performs read-increment-write on the bin chosen by each sample's
// upper bits, and stops when a bin reaches the target.
// Assumes a synchronous memory with read data one cycle after the address.
module hist_accum
    import hist_acc_pkg::*;
#(
    parameter int SAMPLE_W = 24,
    parameter int ADDR_W   = 15,
    parameter int CNT_W    = 16,
    parameter int DROP_W   = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [CNT_W-1:0]    target_i,
    input  logic                smp_valid_i,
    input  logic [SAMPLE_W-1:0] smp_data_i,
    output logic [ADDR_W-1:0]   mem_addr_o,
    output logic                mem_we_o,
    output logic [CNT_W-1:0]    mem_wdata_o,
    input  logic [CNT_W-1:0]    mem_rdata_i,
    output logic                busy_o,
    output logic                done_o,
    output logic [DROP_W-1:0]   drop_cnt_o
);
    localparam int LOW_W = SAMPLE_W - ADDR_W;

    hist_state_e       state_q, state_d;
    logic [ADDR_W-1:0] bin_q;
    logic [ADDR_W-1:0] clr_addr;
    logic              clr_last;
    logic [CNT_W-1:0]  new_count;
    logic              at_target;
    logic              updating;
    logic              unused_low_bits;

    assign unused_low_bits = ^smp_data_i[LOW_W-1:0];

    hist_clear_sweep #(.ADDR_W(ADDR_W)) u_sweep (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (start_i),
        .run     (state_q == ST_CLEAR),
        .addr    (clr_addr),
        .last    (clr_last)
    );

    hist_bin_update #(.CNT_W(CNT_W)) u_update (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (state_q == ST_INCR),
        .rdata   (mem_rdata_i),
        .target  (target_i),
        .count_q (new_count),
        .hit     (at_target)
    );

    assign updating = (state_q == ST_READ) || (state_q == ST_INCR) ||
                      (state_q == ST_WRITE);

    hist_drop_counter #(.DROP_W(DROP_W)) u_drop (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (start_i),
        .inc   (smp_valid_i && updating),
        .cnt   (drop_cnt_o)
    );

    // Next-state logic: start has priority, then the sweep and update sequence.
    always_comb begin
        state_d = state_q;
        if (start_i) begin
            state_d = ST_CLEAR;
        end else begin
            unique case (state_q)
                ST_CLEAR: if (clr_last) state_d = ST_WAIT;
                ST_WAIT:  if (smp_valid_i) state_d = ST_READ;
                ST_READ:  state_d = ST_INCR;
                ST_INCR:  state_d = ST_WRITE;
                ST_WRITE: state_d = at_target ? ST_DONE : ST_WAIT;
                default:  state_d = state_q;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Bin register: captured from the sample's upper bits when accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bin_q <= '0;
        else if (state_q == ST_WAIT && smp_valid_i && !start_i)
            bin_q <= smp_data_i[SAMPLE_W-1 -: ADDR_W];
    end

    // Memory port drive per state.
    always_comb begin
        mem_addr_o  = bin_q;
        mem_we_o    = 1'b0;
        mem_wdata_o = '0;
        if (state_q == ST_CLEAR) begin
            mem_addr_o = clr_addr;
            mem_we_o   = 1'b1;
        end else if (state_q == ST_WRITE) begin
            mem_we_o    = 1'b1;
            mem_wdata_o = new_count;
        end
    end

    assign busy_o = (state_q == ST_CLEAR) || (state_q == ST_WAIT) || updating;
    assign done_o = (state_q == ST_DONE);
endmodule

// File: rtl/hist_acc_checker.sv
// Module: protocol checker for hist_accum, attached by bind.
// Assumes the controller state is visible as state_q.
module hist_acc_checker
    import hist_acc_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DROP_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              busy_o,
    input logic              done_o,
    input logic              mem_we_o,
    input logic [CNT_W-1:0]  mem_wdata_o,
    input logic [DROP_W-1:0] drop_cnt_o,
    input hist_state_e       state_q
);
    AST_SWEEP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CLEAR) |-> (mem_we_o && busy_o && mem_wdata_o == '0)); // R1
    AST_WRITE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> busy_o); // R3
    AST_DROP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> (drop_cnt_o == $past(drop_cnt_o) ||
                      drop_cnt_o == $past(drop_cnt_o) + 1'b1)); // R4
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && busy_o)); // R5
    AST_DONE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o); // R6
    AST_RESTART_SWEEP: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (state_q == ST_CLEAR && busy_o && !done_o && drop_cnt_o == '0)); // R7
endmodule

bind hist_accum hist_acc_checker #(.CNT_W(CNT_W), .DROP_W(DROP_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .mem_we_o    (mem_we_o),
    .mem_wdata_o (mem_wdata_o),
    .drop_cnt_o  (drop_cnt_o),
    .state_q     (state_q)
);

// File: tb/tb_hist_accum.sv
// Bench: small memory (16 bins), table-driven accumulation runs, then
// directed reset, drop and restart tests.
module tb_hist_accum;
    localparam int SW = 24;
    localparam int AW = 4;
    localparam int CW = 16;
    localparam int DW = 16;
    localparam int NB = 1 << AW;
    localparam int NROW = 5;
    // Row: {target[23:8], base bin[7:4], bin stride[3:0]}
    localparam logic [23:0] ROWS [NROW] = '{
        {16'd3, 4'd5,  4'd0},
        {16'd2, 4'd0,  4'd1},
        {16'd4, 4'd2,  4'd3},
        {16'd1, 4'd15, 4'd1},
        {16'd0, 4'd9,  4'd4}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [CW-1:0] target = '0;
    logic          svalid = 1'b0;
    logic [SW-1:0] sdata = '0;
    logic [AW-1:0] maddr;
    logic          mwe;
    logic [CW-1:0] mwdata;
    logic [CW-1:0] mrdata = '0;
    logic          busy, done;
    logic [DW-1:0] drops;
    logic          junk_en = 1'b0;
    logic [CW-1:0] mem [NB];
    int            model [NB];
    int            checks = 0;
    int            errors = 0;
    int            cyc = 0;

    always #2.5 clk = ~clk;

    hist_accum #(.SAMPLE_W(SW), .ADDR_W(AW), .CNT_W(CW), .DROP_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .target_i(target),
        .smp_valid_i(svalid), .smp_data_i(sdata),
        .mem_addr_o(maddr), .mem_we_o(mwe), .mem_wdata_o(mwdata),
        .mem_rdata_i(mrdata), .busy_o(busy), .done_o(done), .drop_cnt_o(drops)
    );

    // Synchronous single-port memory model, with a preload of nonzero junk.
    always @(posedge clk) begin
        if (junk_en) begin
            for (int j = 0; j < NB; j++) mem[j] <= CW'(16'hA5A0 + j);
        end else if (mwe) begin
            mem[maddr] <= mwdata;
        end
        mrdata <= mem[maddr];
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic preload();
        @(negedge clk) junk_en = 1'b1;
        @(negedge clk) junk_en = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    // One sample, then idle long enough for the whole update to finish.
    task automatic send(input logic [AW-1:0] bin, input int n);
        @(negedge clk);
        svalid = 1'b1;
        sdata  = {bin, 20'(n * 37) ^ 20'h5A5A5};
        @(negedge clk) svalid = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic check_all_zero(input string req);
        int nz = 0;
        for (int j = 0; j < NB; j++) if (mem[j] != '0) nz++;
        chk(nz == 0, req, nz, 0);
    endtask

    initial begin
        int tgt;
        int n;
        bit hit;
        logic [AW-1:0] base, stride, bin;
        logic [CW-1:0] keep;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 reset state
        chk(busy == 1'b0 && done == 1'b0, "R8 busy/done after reset", {busy, done}, 0);
        chk(mwe == 1'b0 && drops == '0, "R8 write enable/drops after reset", {mwe, drops}, 0);

        // R6 sample while idle has no effect
        preload();
        send(4'd3, 1);
        chk(mem[3] == 16'hA5A3, "R6 idle sample ignored", mem[3], 16'hA5A3);
        chk(drops == '0, "R6 idle sample not counted", drops, 0);

        // Table-driven accumulation runs
        for (int r = 0; r < NROW; r++) begin
            tgt    = int'(ROWS[r][23:8]);
            base   = ROWS[r][7:4];
            stride = ROWS[r][3:0];
            preload();
            target = CW'(tgt);
            pulse_start();
            repeat (NB + 1) @(negedge clk);
            check_all_zero("R1 memory cleared");
            chk(busy == 1'b1 && done == 1'b0, "R1 busy after clear", {busy, done}, 2);
            for (int j = 0; j < NB; j++) model[j] = 0;
            n = 0;
            hit = 1'b0;
            while (!hit && n < 64) begin
                bin = AW'(base + AW'(n) * stride);
                send(bin, n);
                model[bin] = model[bin] + 1;
                n = n + 1;
                hit = (model[bin] >= tgt);
                if (!hit) chk(done == 1'b0 && busy == 1'b1, "R5 running below target", {busy, done}, 2);
            end
            chk(done == 1'b1 && busy == 1'b0, "R5 stop on target", {busy, done}, 1);
            for (int j = 0; j < NB; j++)
                chk(int'(mem[j]) == model[j], "R3 R2 bin count", mem[j], model[j]);
            chk(drops == '0, "R4 no drops when spaced", drops, 0);
            keep = mem[base];
            send(base, 99);
            chk(mem[base] == keep && done == 1'b1, "R6 done holds, sample ignored", mem[base], keep);
        end

        // R4 back-to-back samples while an update is in flight
        target = 16'd100;
        pulse_start();
        repeat (NB + 1) @(negedge clk);
        @(negedge clk);
        svalid = 1'b1;
        sdata  = {4'd7, 20'h12345};
        repeat (5) @(negedge clk);
        svalid = 1'b0;
        repeat (5) @(negedge clk);
        chk(mem[7] == 16'd2, "R4 accepted samples in bin 7", mem[7], 2);
        chk(drops == 16'd3, "R4 dropped sample count", drops, 3);

        // R7 restart while busy, with samples during the new sweep
        send(4'd1, 5);
        send(4'd1, 6);
        chk(mem[1] == 16'd2, "R7 bin 1 before restart", mem[1], 2);
        pulse_start();
        chk(busy == 1'b1 && done == 1'b0 && drops == '0, "R7 restart state", {busy, done, drops}, 1 << 17);
        svalid = 1'b1;
        sdata  = {4'd2, 20'h0};
        repeat (NB - 4) @(negedge clk);
        svalid = 1'b0;
        repeat (6) @(negedge clk);
        check_all_zero("R7 R1 restart clears, sweep samples ignored");
        chk(drops == '0, "R1 sweep samples not dropped", drops, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule